// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This unit keeps two stack pointers for a small 8-bit processor that shares one 256-byte data RAM between a return stack and an operand stack. The return stack grows upward. Interrupt entry and subroutine call each save the 13-bit program counter and the carry and zero flags as two bytes. Subroutine return and interrupt return read those bytes back. The operand stack grows downward and serves single-byte push and pop. It starts from address zero, so the first push lands at the top of RAM.

The core presents one request per cycle on `op_valid`/`op`, together with the accumulator value, the current PC and the current flags. The unit drives the RAM address, write data and write enable directly, and the RAM read port returns data in the same cycle. Restored PC and flags, popped bytes and the old operand pointer come back on registered outputs. The unit also owns the global interrupt enable: entry clears it and interrupt return sets it.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, both pointers read 0, `gie` is 0, `busy` is 0, and `ram_we` stays low while no request is presented.
- R2: Op 2 (interrupt entry) and op 3 (call) write PC[7:0] at `psp` in the request cycle. In the next cycle, with `busy` high, they write {carry, zero, 0, PC[12:8]} at `psp`+1. `psp` ends 2 higher.
- R3: Op 2 clears `gie` at the edge that accepts it. Op 3 leaves `gie` unchanged.
- R4: Op 5 (interrupt return) reads address `psp`-1, then `psp`-2. In the cycle after the second read, `pc_out`, `carry_out` and `zero_out` hold the restored values, `ret_valid` is high for one cycle, `gie` is 1, and `psp` is 2 lower.
- R5: Op 4 (return) restores `pc_out` the same way and lowers `psp` by 2. It leaves `carry_out`, `zero_out` and `gie` unchanged.
- R6: Op 6 (push) writes `acc_in` at `dsp`-1 and leaves `dsp` at that address. A push at `dsp` = 0 writes address 0xFF.
- R7: Op 7 (pop) reads at `dsp`. One cycle later `pop_data` holds the byte and `pop_valid` is high, and `dsp` has risen by 1, wrapping from 0xFF to 0.
- R8: Op 0 loads `psp` from `acc_in`.
- R9: Op 1 loads `dsp` from `acc_in`. One cycle later `xchg_out` holds the old `dsp`.
- R10: A request presented while `busy` is high is ignored. It changes neither pointer nor any RAM byte other than the one written by the two-byte operation in progress.
- R11: Return-stack arithmetic wraps modulo 256. A call with `psp` = 0xFF writes 0xFF and then 0x00, and leaves `psp` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op | input | 3 | Request code (0 load psp, 1 exchange dsp, 2 interrupt entry, 3 call, 4 return, 5 interrupt return, 6 push, 7 pop) |
| acc_in | input | 8 | Accumulator value for push, load and exchange |
| pc_in | input | 13 | Program counter to save |
| carry_in | input | 1 | Carry flag to save |
| zero_in | input | 1 | Zero flag to save |
| ram_rdata | input | 8 | RAM read data for `ram_addr`, same cycle |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| busy | output | 1 | Second cycle of a two-byte operation |
| pc_out | output | 13 | Restored program counter |
| carry_out | output | 1 | Restored carry flag |
| zero_out | output | 1 | Restored zero flag |
| ret_valid | output | 1 | Restore completed last cycle |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | Pop completed last cycle |
| xchg_out | output | 8 | Operand pointer value before the last exchange |
| gie | output | 1 | Global interrupt enable |
| psp | output | 8 | Return stack pointer |
| dsp | output | 8 | Operand stack pointer |

## Verification
The RAM port can be claimed twice in one cycle. The second byte of an interrupt entry or call is being written, and a push or pop on the operand stack arrives at the same moment. The bench holds a push request high through the busy cycle of an interrupt entry. It then checks that `dsp` has not moved, that the byte below `dsp` still holds its old value, and that the return stack received both of its bytes. A table of pushes and pops judges ordering, and further directed cases cover both pointers crossing the 0xFF/0x00 boundary.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op,
  input  logic [7:0]  acc_in,
  input  logic [12:0] pc_in,
  input  logic        carry_in,
  input  logic        zero_in,
  input  logic [7:0]  ram_rdata,
  output logic [7:0]  ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  output logic        busy,
  output logic [12:0] pc_out,
  output logic        carry_out,
  output logic        zero_out,
  output logic        ret_valid,
  output logic [7:0]  pop_data,
  output logic        pop_valid,
  output logic [7:0]  xchg_out,
  output logic        gie,
  output logic [7:0]  psp,
  output logic [7:0]  dsp
);
  localparam logic [2:0] OP_LDPSP = 3'd0, OP_XCHG = 3'd1, OP_INTA = 3'd2, OP_CALL = 3'd3,
                         OP_RET   = 3'd4, OP_RETI = 3'd5, OP_PUSH = 3'd6, OP_POP  = 3'd7;

  logic       phase;
  logic [2:0] op_q;
  logic [7:0] hold;

  wire accept  = op_valid & ~phase;
  wire q_save  = (op_q == OP_INTA) | (op_q == OP_CALL);
  wire [7:0] psp_m1 = psp - 8'd1;

  assign busy = phase;

  always_comb begin
    ram_addr  = dsp;
    ram_wdata = acc_in;
    ram_we    = 1'b0;
    if (phase) begin
      if (q_save) begin
        ram_addr  = psp;
        ram_wdata = hold;
        ram_we    = 1'b1;
      end else begin
        ram_addr = psp_m1;
      end
    end else if (op_valid) begin
      case (op)
        OP_INTA, OP_CALL: begin
          ram_addr  = psp;
          ram_wdata = pc_in[7:0];
          ram_we    = 1'b1;
        end
        OP_RET, OP_RETI: ram_addr = psp_m1;
        OP_PUSH: begin
          ram_addr = dsp - 8'd1;
          ram_we   = 1'b1;
        end
        default: ram_addr = dsp;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      op_q      <= OP_LDPSP;
      hold      <= 8'h00;
      psp       <= 8'h00;
      dsp       <= 8'h00;
      gie       <= 1'b0;
      pc_out    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      ret_valid <= 1'b0;
      pop_data  <= 8'h00;
      pop_valid <= 1'b0;
      xchg_out  <= 8'h00;
    end else begin
      ret_valid <= 1'b0;
      pop_valid <= 1'b0;
      if (phase) begin
        phase <= 1'b0;
        if (q_save) begin
          psp <= psp + 8'd1;
        end else begin
          psp       <= psp_m1;
          pc_out    <= {hold[4:0], ram_rdata};
          ret_valid <= 1'b1;
          if (op_q == OP_RETI) begin
            carry_out <= hold[7];
            zero_out  <= hold[6];
            gie       <= 1'b1;
          end
        end
      end else if (accept) begin
        op_q <= op;
        case (op)
          OP_LDPSP: psp <= acc_in;
          OP_XCHG: begin
            dsp      <= acc_in;
            xchg_out <= dsp;
          end
          OP_INTA, OP_CALL: begin
            if (op == OP_INTA) gie <= 1'b0;
            psp   <= psp + 8'd1;
            hold  <= {carry_in, zero_in, 1'b0, pc_in[12:8]};
            phase <= 1'b1;
          end
          OP_RET, OP_RETI: begin
            psp   <= psp_m1;
            hold  <= ram_rdata;
            phase <= 1'b1;
          end
          OP_PUSH: dsp <= dsp - 8'd1;
          default: begin
            pop_data  <= ram_rdata;
            pop_valid <= 1'b1;
            dsp       <= dsp + 8'd1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op,
  input logic       busy,
  input logic       gie,
  input logic [7:0] psp,
  input logic [7:0] dsp,
  input logic       pop_valid,
  input logic       ret_valid,
  input logic       ram_we
);
  wire acc = op_valid && !busy;

  assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_psp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 3'd2 || op == 3'd3)) |=> busy ##1 (psp == 8'($past(psp, 2) + 8'd2)));
  assert_entry_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd2) |=> !gie);
  assert_reti_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd5) |=> ##1 (gie && ret_valid));
  assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd6) |=> (dsp == 8'($past(dsp) - 8'd1)));
  assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd7) |=> (pop_valid && dsp == 8'($past(dsp) + 8'd1)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !busy) |-> !ram_we);
  assert_busy_hold_dsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dsp));
endmodule

bind stack_ptr_unit stack_ptr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .busy(busy), .gie(gie),
  .psp(psp), .dsp(dsp), .pop_valid(pop_valid), .ret_valid(ret_valid), .ram_we(ram_we)
);

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [7:0]  acc_in = 8'h00;
  logic [12:0] pc_in = '0;
  logic        carry_in = 1'b0, zero_in = 1'b0;
  logic [7:0]  ram_rdata, ram_addr, ram_wdata, pop_data, xchg_out, psp, dsp;
  logic        ram_we, busy, carry_out, zero_out, ret_valid, pop_valid, gie;
  logic [12:0] pc_out;
  logic [7:0]  mem [256];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  stack_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .acc_in(acc_in), .pc_in(pc_in),
    .carry_in(carry_in), .zero_in(zero_in), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .busy(busy), .pc_out(pc_out),
    .carry_out(carry_out), .zero_out(zero_out), .ret_valid(ret_valid), .pop_data(pop_data),
    .pop_valid(pop_valid), .xchg_out(xchg_out), .gie(gie), .psp(psp), .dsp(dsp)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  // {op, acc, expected dsp after, expected data}
  localparam logic [26:0] VEC [9] = '{
    {3'd1, 8'h20, 8'h20, 8'h00},
    {3'd6, 8'h11, 8'h1F, 8'h11},
    {3'd6, 8'h22, 8'h1E, 8'h22},
    {3'd6, 8'h33, 8'h1D, 8'h33},
    {3'd7, 8'h00, 8'h1E, 8'h33},
    {3'd7, 8'h00, 8'h1F, 8'h22},
    {3'd6, 8'h44, 8'h1E, 8'h44},
    {3'd7, 8'h00, 8'h1F, 8'h44},
    {3'd7, 8'h00, 8'h20, 8'h11}
  };

  task automatic check(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [7:0] a, input logic [12:0] pc,
                       input logic c, input logic z, input int ncyc);
    @(negedge clk);
    op_valid = 1'b1; op = o; acc_in = a; pc_in = pc; carry_in = c; zero_in = z;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    for (int k = 1; k < ncyc; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 psp", psp, 0);
    check("R1 dsp", dsp, 0);
    check("R1 gie", gie, 0);
    check("R1 busy", busy, 0);
    check("R1 we", ram_we, 0);

    for (int i = 0; i < 9; i++) begin
      logic [26:0] v;
      v = VEC[i];
      issue(v[26:24], v[23:16], 13'h0, 1'b0, 1'b0, 1);
      check("R6/R7/R9 dsp", dsp, v[15:8]);
      case (v[26:24])
        3'd6: check("R6 pushed byte", mem[dsp], v[7:0]);
        3'd7: begin
          check("R7 pop data", pop_data, v[7:0]);
          check("R7 pop valid", pop_valid, 1);
        end
        default: check("R9 old dsp", xchg_out, v[7:0]);
      endcase
    end

    // R2/R3 call keeps gie
    issue(3'd3, 8'h00, 13'h0123, 1'b0, 1'b1, 2);
    check("R2 byte0", mem[0], 8'h23);
    check("R2 byte1", mem[1], 8'h41);
    check("R2 psp", psp, 2);
    check("R3 call gie", gie, 0);
    // R4 interrupt return
    issue(3'd5, 8'h00, 13'h0, 1'b0, 1'b0, 2);
    check("R4 pc", pc_out, 13'h0123);
    check("R4 carry", carry_out, 0);
    check("R4 zero", zero_out, 1);
    check("R4 ret_valid", ret_valid, 1);
    check("R4 gie", gie, 1);
    check("R4 psp", psp, 0);
    // R2/R3 interrupt entry, busy in second cycle
    @(negedge clk);
    op_valid = 1'b1; op = 3'd2; pc_in = 13'h1ABC; carry_in = 1'b1; zero_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 busy", busy, 1);
    check("R3 entry gie", gie, 0);
    @(posedge clk);
    @(negedge clk);
    check("R2 entry byte0", mem[0], 8'hBC);
    check("R2 entry byte1", mem[1], 8'h9A);
    check("R2 entry psp", psp, 2);
    // R5 plain return
    issue(3'd4, 8'h00, 13'h0, 1'b0, 1'b0, 2);
    check("R5 pc", pc_out, 13'h1ABC);
    check("R5 carry kept", carry_out, 0);
    check("R5 zero kept", zero_out, 1);
    check("R5 gie kept", gie, 0);
    check("R5 psp", psp, 0);
    // R10 push held during busy cycle
    @(negedge clk);
    op_valid = 1'b1; op = 3'd2; pc_in = 13'h0777; carry_in = 1'b0; zero_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op = 3'd6; acc_in = 8'hEE;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R10 dsp", dsp, 8'h20);
    check("R10 ram", mem[8'h1F], 8'h11);
    check("R10 psp", psp, 2);
    check("R10 entry byte0", mem[0], 8'h77);
    // R8/R11 load and wrap
    issue(3'd0, 8'hFF, 13'h0, 1'b0, 1'b0, 1);
    check("R8 psp load", psp, 8'hFF);
    issue(3'd3, 8'h00, 13'h0055, 1'b1, 1'b1, 2);
    check("R11 byte at FF", mem[8'hFF], 8'h55);
    check("R11 byte at 00", mem[0], 8'hC0);
    check("R11 psp", psp, 1);
    // R6/R7 operand stack wrap
    issue(3'd1, 8'h00, 13'h0, 1'b0, 1'b0, 1);
    check("R9 old dsp", xchg_out, 8'h20);
    issue(3'd6, 8'h5A, 13'h0, 1'b0, 1'b0, 1);
    check("R6 wrap addr", mem[8'hFF], 8'h5A);
    check("R6 wrap dsp", dsp, 8'hFF);
    issue(3'd7, 8'h00, 13'h0, 1'b0, 1'b0, 1);
    check("R7 wrap data", pop_data, 8'h5A);
    check("R7 wrap dsp", dsp, 0);
    finish_run();
  end
endmodule